// File: doc/BRIEF.md
# Paired Reset-Synchronous PWM Timer

The block holds two up-counters, a master and a slave, that run in lockstep as one PWM pair. A single run bit on the master launches both counters. The slave uses no prescale setting of its own: every count step of both counters comes from the master's divide select. When compare-clear is chosen, both counters return to zero on the same cycle once the master count equals the shared period value. Each channel drives one PWM output from its own duty value.

Each channel also keeps an overflow flag. Software clears it by writing a zero. The way the flags respond when the period is all-ones (0xFFFF at the default width) depends on two inputs. One selects the standard or the masked variant. The other is a pair of per-channel synchronous-clear enables. This lets a host pick the flag behaviour it expects when the period is full-scale.

Top module: `pwm_pair_timer`

## Requirements
- R1: Out of reset both counts are 0, both flags are 0 and both PWM outputs are 1. The counts advance only while `start` is 1 and hold their value while it is 0.
- R2: `div_sel` picks the count rate: 0 gives /1, 1 gives /4, 2 gives /16 and 3 gives /64. After `start` rises, both counts reach k after exactly k*N clock edges, where N is the selected divisor.
- R3: The two counts are always equal. With `clr_on_period` at 1, a count step taken while the master count equals `period` sets both counts to 0.
- R4: With `clr_on_period` at 1 and `period` below all-ones, neither overflow flag is ever set.
- R5: In the standard variant (`mask_mode`=0), with the period at all-ones, compare-clear selected and `sync_en` not 2'b11, the clear to 0 leaves `ovf_m` at 0 and sets `ovf_s`.
- R6: In the masked variant (`mask_mode`=1), under the same conditions as R5, neither flag is set when the counts clear.
- R7: In the standard variant with `sync_en`=2'b11 (bit 0 master, bit 1 slave), the full-scale compare-clear sets neither flag.
- R8: With `clr_on_period` at 0, stepping past all-ones wraps both counts to 0 and sets both flags on that cycle.
- R9: Strobing `ovf_wr[i]` with `ovf_wdata[i]`=0 clears flag i on the next edge. A data bit of 1 leaves the flag unchanged. A set and a clear on the same edge leave the flag at 1. Bit 0 addresses the master and bit 1 the slave.
- R10: Each PWM output is 1 while its count is at or below its duty value and 0 while the count is above it. It returns to 1 on the step that clears or wraps the count. A duty value at or above the period keeps the output at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Master run bit; launches both counters |
| div_sel | input | 2 | Master divide select, shared by the slave |
| clr_on_period | input | 1 | Clear both counts on a period match |
| period | input | CNT_W | Shared period compare value |
| duty_m | input | CNT_W | Master duty compare value |
| duty_s | input | CNT_W | Slave duty compare value |
| mask_mode | input | 1 | 1 selects the masked flag variant |
| sync_en | input | 2 | Synchronous-clear enable per channel |
| ovf_wr | input | 2 | Flag write strobe per channel |
| ovf_wdata | input | 2 | Flag write data; 0 clears |
| cnt_m | output | CNT_W | Master count |
| cnt_s | output | CNT_W | Slave count |
| ovf_m | output | 1 | Master overflow flag |
| ovf_s | output | 1 | Slave overflow flag |
| pwm_m | output | 1 | Master PWM output |
| pwm_s | output | 1 | Slave PWM output |

## Verification
Every output is a register, so a count step, a clear, a flag change or a PWM change is visible one clock edge after the cycle that triggers it. Through the prescaler this means a count of k appears k*N edges after `start` rises. The bench drives inputs on falling edges and counts the edges itself. At the falling edge after edge k it queues the value the requirements give for that edge, and the monitor compares it before the next rising edge. The full-scale corner is exercised with an 8-bit build, where the wrap falls on edge 256 after start. A flag write is checked on the edge after its strobe, including a strobe placed on the wrap edge itself.

// File: rtl/ppt_pkg.sv
`timescale 1ns/1ps
package ppt_pkg;
   localparam int NUM_CH  = 2;
   localparam int CH_MAST = 0;
   localparam int CH_SLV  = 1;

   typedef enum logic [1:0] {
      DIV_1  = 2'd0,
      DIV_4  = 2'd1,
      DIV_16 = 2'd2,
      DIV_64 = 2'd3
   } div_e;
endpackage

// File: rtl/ppt_prescaler.sv
`timescale 1ns/1ps
module ppt_prescaler #(
   parameter int PRE_W      = 6,
   parameter int SEL_W      = 2,
   parameter int SHIFT_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int MAX_SHIFT = SHIFT_STEP * ((1 << SEL_W) - 1);

   if (PRE_W < MAX_SHIFT) begin : g_bad_width
      $error("ppt_prescaler: PRE_W too small for the largest divisor");
   end

   logic [PRE_W-1:0] phase;
   logic [PRE_W-1:0] mask;

   always_comb begin
      mask = PRE_W'((32'd1 << (SHIFT_STEP * int'(sel))) - 32'd1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   phase <= '0;
      else if (!run) phase <= '0;
      else          phase <= phase + 1'b1;
   end

   assign tick = run && ((phase & mask) == mask);
endmodule

// File: rtl/ppt_counter_pair.sv
`timescale 1ns/1ps
module ppt_counter_pair #(
   parameter int CNT_W = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 tick,
   input  logic                                 clr_sel,
   input  logic [CNT_W-1:0]                     period,
   output logic [ppt_pkg::NUM_CH-1:0][CNT_W-1:0] cnt,
   output logic                                 restart,
   output logic                                 wrap_evt,
   output logic                                 full_clr
);
   import ppt_pkg::*;
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   logic cmp_hit;
   logic at_full;

   // master count decides the compare for both channels
   assign cmp_hit  = clr_sel && (cnt[CH_MAST] == period);
   assign at_full  = (cnt[CH_MAST] == FULL);
   assign wrap_evt = tick && !cmp_hit && at_full;
   assign full_clr = tick && cmp_hit && at_full;
   assign restart  = tick && (cmp_hit || at_full);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)        cnt[g] <= '0;
         else if (tick) begin
            if (cmp_hit)    cnt[g] <= '0;
            else            cnt[g] <= cnt[g] + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ppt_channel.sv
`timescale 1ns/1ps
module ppt_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic             set_ovf,
   input  logic             wr,
   input  logic             wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] duty,
   output logic             ovf,
   output logic             pwm
);
   always_ff @(posedge clk) begin
      if (!rst_n)             ovf <= 1'b0;
      else if (set_ovf)       ovf <= 1'b1;
      else if (wr && !wdata)  ovf <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     pwm <= 1'b1;
      else if (restart)               pwm <= 1'b1;
      else if (tick && cnt == duty)   pwm <= 1'b0;
   end
endmodule

// File: rtl/pwm_pair_timer.sv
`timescale 1ns/1ps
module pwm_pair_timer #(
   parameter int CNT_W      = 16,
   parameter int PRE_W      = 6,
   parameter int SEL_W      = 2,
   parameter int SHIFT_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             clr_on_period,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] duty_m,
   input  logic [CNT_W-1:0] duty_s,
   input  logic             mask_mode,
   input  logic [1:0]       sync_en,
   input  logic [1:0]       ovf_wr,
   input  logic [1:0]       ovf_wdata,
   output logic [CNT_W-1:0] cnt_m,
   output logic [CNT_W-1:0] cnt_s,
   output logic             ovf_m,
   output logic             ovf_s,
   output logic             pwm_m,
   output logic             pwm_s
);
   import ppt_pkg::*;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("pwm_pair_timer: CNT_W must be at least 2");
   end

   logic                          tick;
   logic [NUM_CH-1:0][CNT_W-1:0]  cnt;
   logic [NUM_CH-1:0][CNT_W-1:0]  duty;
   logic                          restart;
   logic                          wrap_evt;
   logic                          full_clr;
   logic [NUM_CH-1:0]             ovf_set;
   logic [NUM_CH-1:0]             ovf_q;
   logic [NUM_CH-1:0]             pwm_q;
   logic                          both_sync;

   assign duty[CH_MAST] = duty_m;
   assign duty[CH_SLV]  = duty_s;
   assign both_sync     = &sync_en;

   ppt_prescaler #(
      .PRE_W(PRE_W), .SEL_W(SEL_W), .SHIFT_STEP(SHIFT_STEP)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .run(start), .sel(div_sel), .tick(tick)
   );

   ppt_counter_pair #(.CNT_W(CNT_W)) u_pair (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr_sel(clr_on_period),
      .period(period), .cnt(cnt), .restart(restart),
      .wrap_evt(wrap_evt), .full_clr(full_clr)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      if (ch == CH_MAST) begin : g_set_mast
         // the master's own compare-clear never counts as an overflow
         assign ovf_set[ch] = wrap_evt;
      end else begin : g_set_slv
         // the slave sees the full-scale clear as a wrap unless masked or synced
         assign ovf_set[ch] = wrap_evt | (full_clr & ~mask_mode & ~both_sync);
      end

      ppt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
         .set_ovf(ovf_set[ch]), .wr(ovf_wr[ch]), .wdata(ovf_wdata[ch]),
         .cnt(cnt[ch]), .duty(duty[ch]), .ovf(ovf_q[ch]), .pwm(pwm_q[ch])
      );
   end

   assign cnt_m = cnt[CH_MAST];
   assign cnt_s = cnt[CH_SLV];
   assign ovf_m = ovf_q[CH_MAST];
   assign ovf_s = ovf_q[CH_SLV];
   assign pwm_m = pwm_q[CH_MAST];
   assign pwm_s = pwm_q[CH_SLV];
endmodule

// File: rtl/ppt_checker.sv
`timescale 1ns/1ps
module ppt_checker #(
   parameter int CNT_W = 16,
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [SEL_W-1:0] div_sel,
   input logic             clr_on_period,
   input logic [CNT_W-1:0] period,
   input logic             mask_mode,
   input logic [1:0]       ovf_wr,
   input logic [1:0]       ovf_wdata,
   input logic [CNT_W-1:0] cnt_m,
   input logic [CNT_W-1:0] cnt_s,
   input logic             ovf_m,
   input logic             ovf_s,
   input logic             pwm_m
);
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(cnt_m));

   a_r3_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_m == cnt_s);

   a_r3_period_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (start && div_sel == '0 && clr_on_period && cnt_m == period) |=> (cnt_m == '0));

   a_r5_master_quiet_at_full: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_on_period && period == FULL) |=> !$rose(ovf_m));

   a_r6_mask_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_mode && clr_on_period && period == FULL) |=> !$rose(ovf_s));

   a_r8_flag_rises_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_s) |-> (cnt_s == '0));

   a_r9_write_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && ovf_wr[0] && !ovf_wdata[0]) |=> !ovf_m);

   a_r10_pwm_rises_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_m) |-> (cnt_m == '0));
endmodule

bind pwm_pair_timer ppt_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .div_sel(div_sel),
   .clr_on_period(clr_on_period), .period(period), .mask_mode(mask_mode),
   .ovf_wr(ovf_wr), .ovf_wdata(ovf_wdata), .cnt_m(cnt_m), .cnt_s(cnt_s),
   .ovf_m(ovf_m), .ovf_s(ovf_s), .pwm_m(pwm_m)
);

// File: tb/pwm_pair_timer_test.sv
`timescale 1ns/1ps
module pwm_pair_timer_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic [1:0]   div_sel;
   logic         clr_on_period;
   logic [W-1:0] period, duty_m, duty_s;
   logic         mask_mode;
   logic [1:0]   sync_en, ovf_wr, ovf_wdata;
   logic [W-1:0] cnt_m, cnt_s;
   logic         ovf_m, ovf_s, pwm_m, pwm_s;

   always #10 clk = ~clk;

   pwm_pair_timer #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .div_sel(div_sel),
      .clr_on_period(clr_on_period), .period(period), .duty_m(duty_m),
      .duty_s(duty_s), .mask_mode(mask_mode), .sync_en(sync_en),
      .ovf_wr(ovf_wr), .ovf_wdata(ovf_wdata), .cnt_m(cnt_m), .cnt_s(cnt_s),
      .ovf_m(ovf_m), .ovf_s(ovf_s), .pwm_m(pwm_m), .pwm_s(pwm_s)
   );

   typedef struct {
      string req;
      int    sig;
      int    val;
   } item_t;

   item_t q[$];
   event  mon_ev;
   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 0;

   localparam int S_CM = 0, S_CS = 1, S_OM = 2, S_OS = 3, S_PM = 4, S_PS = 5;

   function automatic int sample(int sig);
      case (sig)
         S_CM:    return int'(cnt_m);
         S_CS:    return int'(cnt_s);
         S_OM:    return int'(ovf_m);
         S_OS:    return int'(ovf_s);
         S_PM:    return int'(pwm_m);
         default: return int'(pwm_s);
      endcase
   endfunction

   // monitor: pop queued expectations and compare them against the ports
   initial begin
      forever begin
         @(mon_ev);
         while (q.size() != 0) begin
            item_t it;
            int    act;
            it  = q.pop_front();
            act = sample(it.sig);
            n_checks++;
            if (act != it.val) begin
               n_errors++;
               $display("FAIL %s sig%0d actual %0d expected %0d", it.req, it.sig, act, it.val);
            end
         end
      end
   end

   // driver side: push one expectation, wake the monitor
   task automatic expect_val(string req, int sig, int val);
      item_t it;
      it.req = req; it.sig = sig; it.val = val;
      q.push_back(it);
      -> mon_ev;
      #1;
   endtask

   task automatic edges(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; start = 1'b0; div_sel = 2'd0; clr_on_period = 1'b0;
      period = '0; duty_m = '1; duty_s = '1; mask_mode = 1'b0;
      sync_en = 2'b00; ovf_wr = 2'b00; ovf_wdata = 2'b11;
      edges(3);
      rst_n = 1'b1;
      edges(1);
   endtask

   task automatic full_scale_run(bit msk, logic [1:0] syn, bit clr, int exp_m, int exp_s, string req);
      do_reset();
      period = '1; clr_on_period = clr; mask_mode = msk; sync_en = syn;
      start = 1'b1;
      edges(255);
      expect_val(req, S_CM, 255);
      expect_val(req, S_OS, 0);
      edges(1);
      expect_val(req, S_CM, 0);
      expect_val(req, S_CS, 0);
      expect_val(req, S_OM, exp_m);
      expect_val(req, S_OS, exp_s);
   endtask

   initial begin
      #(100000 * 20);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      do_reset();
      // R1: reset state
      expect_val("R1", S_CM, 0);
      expect_val("R1", S_CS, 0);
      expect_val("R1", S_OM, 0);
      expect_val("R1", S_OS, 0);
      expect_val("R1", S_PM, 1);
      edges(5);
      expect_val("R1", S_CM, 0);   // not started yet

      // R2: divide by 16, then R1 hold while stopped
      div_sel = 2'd2; start = 1'b1;
      edges(40);
      expect_val("R2", S_CM, 2);
      expect_val("R2", S_CS, 2);
      edges(8);
      expect_val("R2", S_CM, 3);
      start = 1'b0;
      edges(20);
      expect_val("R1", S_CM, 3);
      expect_val("R1", S_CS, 3);

      // R2: divide by 4
      do_reset();
      div_sel = 2'd1; start = 1'b1;
      edges(7);
      expect_val("R2", S_CM, 1);
      edges(1);
      expect_val("R2", S_CM, 2);

      // R2: divide by 64, boundary one edge short
      do_reset();
      div_sel = 2'd3; start = 1'b1;
      edges(127);
      expect_val("R2", S_CS, 1);
      edges(1);
      expect_val("R2", S_CS, 2);

      // R3, R10, R4: period 9, master duty 3, slave duty above period
      do_reset();
      period = 8'd9; clr_on_period = 1'b1; duty_m = 8'd3; duty_s = 8'd12;
      start = 1'b1;
      for (int n = 1; n <= 25; n++) begin
         edges(1);
         expect_val("R3", S_CM, n % 10);
         expect_val("R3", S_CS, n % 10);
         expect_val("R10", S_PM, ((n % 10) <= 3) ? 1 : 0);
         expect_val("R10", S_PS, 1);
      end
      edges(300);
      expect_val("R4", S_OM, 0);
      expect_val("R4", S_OS, 0);

      // R5: standard, no sync, then R9 flag writes
      full_scale_run(1'b0, 2'b00, 1'b1, 0, 1, "R5");
      ovf_wr = 2'b10; ovf_wdata = 2'b10;            // write one: no effect
      edges(1);
      ovf_wr = 2'b00; ovf_wdata = 2'b11;
      expect_val("R9", S_OS, 1);
      ovf_wr = 2'b10; ovf_wdata = 2'b00;            // write zero: clears
      edges(1);
      ovf_wr = 2'b00; ovf_wdata = 2'b11;
      expect_val("R9", S_OS, 0);
      edges(253);                                   // 511 edges since start
      ovf_wr = 2'b10; ovf_wdata = 2'b00;            // clear on the wrap edge
      edges(1);
      ovf_wr = 2'b00; ovf_wdata = 2'b11;
      expect_val("R9", S_OS, 1);
      expect_val("R9", S_CM, 0);

      // R5: only the master synced still sets the slave flag
      full_scale_run(1'b0, 2'b01, 1'b1, 0, 1, "R5");
      // R6: masked variant
      full_scale_run(1'b1, 2'b00, 1'b1, 0, 0, "R6");
      // R7: both synced
      full_scale_run(1'b0, 2'b11, 1'b1, 0, 0, "R7");
      // R8: free-running wrap, PWM back high
      full_scale_run(1'b0, 2'b00, 1'b0, 1, 1, "R8");
      expect_val("R10", S_PM, 1);

      edges(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule